// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a down-counting watchdog with a small memory-mapped register port. Software loads a period, enables the counter, and must service the block before two periods pass. When the counter first reaches zero, the block raises an interrupt and starts a new period. If that interrupt is still pending when the counter reaches zero again, and the reset output is enabled, the block requests a system reset. A full reset therefore takes two load periods. The reset request stays high until the block is reset.

A single write to the interrupt-clear register services the watchdog. That write clears the pending interrupt and restarts the period. All registers except the lock register are protected by a key. A stray write has no effect until the key has been written. A test mode hands the interrupt and reset outputs to software, so that the wiring at the chip level can be checked without waiting for the counter.

The register port uses a 12-bit byte address, a write strobe, 32-bit write data and a combinational 32-bit read path. A write takes effect at the rising clock edge on which the strobe is high.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset the lock register (0xC00) reads 1, the load register (0x000) reads 0xFFFFFFFF, control (0x008) and raw status (0x010) read 0, and both `irq_o` and `rst_req_o` are low.
- R2: The count (0x004) drops by one on each clock while control bit 0 is set. It holds its value while that bit is clear.
- R3: A write to the load register updates both the load value and the count. A control write with bit 0 set reloads the count from the load value.
- R4: While enabled, a clock on which the count is zero sets raw status bit 0 and reloads the count. Masked status (0x014) equals raw status AND control bit 0. Outside test mode, `irq_o` follows the masked status.
- R5: Writing 0x1ACCE551 to 0xC00 unlocks the block, and any other value written there locks it. While the block is locked, writes to every other address are ignored.
- R6: Any unlocked write to 0x00C clears raw status and reloads the count from the load value.
- R7: An expiry that finds raw status already set asserts `rst_req_o`, but only if control bit 1 is set. If bit 1 is clear, the output stays low.
- R8: Once `rst_req_o` is asserted by the counter, it stays high until `rst_ni` is asserted.
- R9: While 0xF00 bit 0 is set, bit 0 of the value last written to 0xF04 drives `rst_req_o` and bit 1 drives `irq_o`. Clearing 0xF00 bit 0 returns both outputs to the counter logic.
- R10: Control bits 31:2 read as zero, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | System reset request |

## Verification
The bench builds the block with its default 32-bit data width and its all-ones load value at reset. The default load value is checked only by reading it back. The bench writes small periods of four and ten cycles, so that the first expiry, the second expiry, the reload and the sticky reset each happen within a few dozen clocks, and their cycle can be predicted exactly. A pulse on the block reset then shows that the sticky reset request is released, and it leaves a clean state for the test-mode checks.

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog #(
  parameter int          DW       = 32,
  parameter int          AW       = 12,
  parameter logic [31:0] KEY      = 32'h1ACC_E551,
  parameter logic [DW-1:0] LOAD_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  localparam logic [AW-1:0] OFF_LOAD  = AW'(12'h000);
  localparam logic [AW-1:0] OFF_COUNT = AW'(12'h004);
  localparam logic [AW-1:0] OFF_CTRL  = AW'(12'h008);
  localparam logic [AW-1:0] OFF_CLR   = AW'(12'h00C);
  localparam logic [AW-1:0] OFF_RAW   = AW'(12'h010);
  localparam logic [AW-1:0] OFF_MASK  = AW'(12'h014);
  localparam logic [AW-1:0] OFF_LOCK  = AW'(12'hC00);
  localparam logic [AW-1:0] OFF_TMODE = AW'(12'hF00);
  localparam logic [AW-1:0] OFF_TOUT  = AW'(12'hF04);

  logic [DW-1:0] load_q, cnt_q;
  logic          en_q, rsten_q, raw_q, lock_q, tmode_q, sticky_q;
  logic [1:0]    tout_q;

  wire wr_ok   = wr_en_i && (!lock_q || addr_i == OFF_LOCK);
  wire masked  = raw_q && en_q;
  wire expired = en_q && cnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q   <= LOAD_RST;
      cnt_q    <= LOAD_RST;
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      raw_q    <= 1'b0;
      lock_q   <= 1'b1;
      tmode_q  <= 1'b0;
      tout_q   <= 2'b00;
      sticky_q <= 1'b0;
    end else if (wr_ok) begin
      case (addr_i)
        OFF_LOAD: begin
          load_q <= wr_data_i;
          cnt_q  <= wr_data_i;
        end
        OFF_CTRL: begin
          en_q    <= wr_data_i[0];
          rsten_q <= wr_data_i[1];
          if (wr_data_i[0]) cnt_q <= load_q;
        end
        OFF_CLR: begin
          raw_q <= 1'b0;
          cnt_q <= load_q;
        end
        OFF_LOCK:  lock_q  <= (wr_data_i[31:0] != KEY);
        OFF_TMODE: tmode_q <= wr_data_i[0];
        OFF_TOUT:  tout_q  <= wr_data_i[1:0];
        default: ;
      endcase
    end else if (expired) begin
      cnt_q <= load_q;
      raw_q <= 1'b1;
      if (raw_q && rsten_q) sticky_q <= 1'b1;
    end else if (en_q) begin
      cnt_q <= cnt_q - DW'(1);
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      OFF_LOAD:  rd_data_o = load_q;
      OFF_COUNT: rd_data_o = cnt_q;
      OFF_CTRL:  rd_data_o[1:0] = {rsten_q, en_q};
      OFF_RAW:   rd_data_o[0] = raw_q;
      OFF_MASK:  rd_data_o[0] = masked;
      OFF_LOCK:  rd_data_o[0] = lock_q;
      OFF_TMODE: rd_data_o[0] = tmode_q;
      default: ;
    endcase
  end

  assign irq_o     = tmode_q ? tout_q[1] : masked;
  assign rst_req_o = tmode_q ? tout_q[0] : sticky_q;

  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && cnt_q != '0 && !wr_en_i |=> cnt_q == $past(cnt_q) - DW'(1));

  a_r5_locked_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && wr_en_i && addr_i != OFF_LOCK |=>
      $stable(load_q) && $stable(en_q) && $stable(rsten_q) && $stable(tmode_q));

  a_r6_clear_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !lock_q && addr_i == OFF_CLR |=> !raw_q && cnt_q == $past(load_q));

  a_r7_reset_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_q) |-> $past(raw_q) && $past(rsten_q) && $past(en_q));

  a_r8_reset_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_q |=> sticky_q);
endmodule

// File: tb/dual_stage_wdog_bench.sv
module dual_stage_wdog_bench;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_CLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_LOCK = 12'hC00, A_TMODE = 12'hF00, A_TOUT = 12'hF04;
  localparam logic [31:0] UNLOCK = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_stage_wdog u_dual_stage_wdog (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq), .rst_req_o(rst_req));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    rd(A_LOCK, v); check("R1 lock", v, 1);
    rd(A_LOAD, v); check("R1 load", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_RAW, v);  check("R1 raw", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst", {31'b0, rst_req}, 0);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(A_LOAD, 5);
    rd(A_LOAD, v); check("R5 locked load write ignored", v, 32'hFFFF_FFFF);
    wr(A_LOCK, UNLOCK);
    rd(A_LOCK, v); check("R5 unlocked", v, 0);
    wr(A_LOAD, 10);
    rd(A_LOAD, v); check("R3 load written", v, 10);
    rd(A_CNT, v);  check("R3 count follows load", v, 10);
    idle(3);
    rd(A_CNT, v);  check("R2 hold while disabled", v, 10);
    wr(A_LOCK, 32'h0);
    rd(A_LOCK, v); check("R5 relocked", v, 1);
    wr(A_LOAD, 7);
    rd(A_LOAD, v); check("R5 relocked write ignored", v, 10);
    wr(A_LOCK, UNLOCK);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFD);
    rd(A_CTRL, v); check("R10 reserved read zero", v, 1);
    rd(A_CNT, v);  check("R3 enable reloads", v, 10);
    idle(4);
    rd(A_CNT, v);  check("R2 decrement", v, 6);
  endtask

  task automatic t_expire;
    logic [31:0] v;
    wr(A_LOAD, 4);
    idle(4);
    rd(A_CNT, v); check("R4 count at zero", v, 0);
    rd(A_RAW, v); check("R4 raw before expiry", v, 0);
    idle(1);
    rd(A_RAW, v); check("R4 raw after expiry", v, 1);
    rd(A_CNT, v); check("R4 reload on expiry", v, 4);
    rd(A_MASK, v); check("R4 masked", v, 1);
    check("R4 irq", {31'b0, irq}, 1);
    wr(A_CTRL, 0);
    rd(A_MASK, v); check("R4 masked off when disabled", v, 0);
    rd(A_RAW, v);  check("R4 raw kept when disabled", v, 1);
    check("R4 irq off when disabled", {31'b0, irq}, 0);
    wr(A_CTRL, 1);
    idle(6);
    check("R7 no reset without enable", {31'b0, rst_req}, 0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    idle(2);
    wr(A_CLR, 32'h1234);
    rd(A_RAW, v); check("R6 raw cleared", v, 0);
    rd(A_CNT, v); check("R6 count reloaded", v, 4);
  endtask

  task automatic t_reset_out;
    logic [31:0] v;
    wr(A_CTRL, 3);
    idle(5);
    rd(A_RAW, v); check("R7 first expiry", v, 1);
    check("R7 no reset at first expiry", {31'b0, rst_req}, 0);
    idle(4);
    check("R7 no reset before second expiry", {31'b0, rst_req}, 0);
    idle(1);
    check("R7 reset at second expiry", {31'b0, rst_req}, 1);
    wr(A_CTRL, 0);
    wr(A_CLR, 1);
    wr(A_LOCK, 0);
    idle(3);
    check("R8 reset sticky", {31'b0, rst_req}, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R8 released by block reset", {31'b0, rst_req}, 0);
  endtask

  task automatic t_testmode;
    logic [31:0] v;
    wr(A_LOCK, UNLOCK);
    wr(A_TMODE, 1);
    rd(A_TMODE, v); check("R9 test mode set", v, 1);
    wr(A_TOUT, 2);
    check("R9 irq driven", {31'b0, irq}, 1);
    check("R9 rst idle", {31'b0, rst_req}, 0);
    wr(A_TOUT, 1);
    check("R9 irq idle", {31'b0, irq}, 0);
    check("R9 rst driven", {31'b0, rst_req}, 1);
    wr(A_TMODE, 0);
    check("R9 rst back to logic", {31'b0, rst_req}, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset_state();
    t_lock();
    t_count();
    t_expire();
    t_clear();
    t_reset_out();
    t_testmode();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule